// File: doc/BRIEF.md
# Precision-Adaptive Gated Multiply-Accumulate Unit

This block is the multiply-accumulate engine of a small edge neural-network accelerator. Each cycle in which `in_valid` is high, it multiplies a signed operand A by an unsigned operand B and adds the product into a 24-bit signed accumulator. A 3-bit mode input chooses the operand widths at run time from six mixed-precision pairs. Only the low-order bits of each operand are used in the narrow modes: A is sign-extended from its selected width and B is zero-extended.

The product comes from a shift-and-add multiplier. A shifted copy of A enters the sum only for the set bits of B. If either narrowed operand is zero, the multiplier and the accumulator update are both skipped. The accumulator is built from three 8-bit carry-lookahead segments joined by ripple carries. Each segment loads a new value only when the current precision needs it, when a carry reaches it, or when the sign-extended product has a nonzero byte at its position. An idle segment keeps its register unchanged. The sum always equals a full-width add.

Gating is modelled as per-segment load enables, not as clock cells. A synchronous clear empties the accumulator.

Top module: `mixed_prec_mac`

## Requirements
- R1: `mode` selects (A width × B width) as 0=2×2, 1=2×4, 2=2×8, 3=4×4, 4=4×8, 5=8×8. A is taken from its low bits and sign-extended, B is taken from its low bits and zero-extended, and higher operand bits have no effect.
- R2: Mode values 6 and 7 behave exactly as mode 5 (8×8).
- R3: When `in_valid` is high and `clr` is low, `acc_out` equals the old value plus A×B (signed × unsigned) after the next rising clock edge. One product is accumulated per valid cycle.
- R4: When `in_valid` is low and `clr` is low, `acc_out` keeps its value.
- R5: When `clr` is high, `acc_out` becomes zero after the next rising edge, whatever `in_valid` and the operands are.
- R6: If the narrowed A or the narrowed B is zero, no accumulator segment is enabled and `acc_out` keeps its value.
- R7: The multiplier adds a shifted copy of A for each set bit of the narrowed B and none for its clear bits. With a zero operand, no partial product is generated.
- R8: A segment that is not enabled keeps its 8-bit slice. Upper segments wake up on an incoming carry or a nonzero sign-extension byte, so sums that cross segment boundaries upward or downward are exact.
- R9: The accumulator wraps modulo 2^24. A positive product that carries out of the top segment leaves a smaller unsigned value.
- R10: After the asynchronous active-low reset, `acc_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous accumulator clear; takes priority over `in_valid` |
| in_valid | input | 1 | Accumulate the current operand pair |
| mode | input | 3 | Precision pair select (see R1, R2) |
| op_a | input | 8 | Operand A, signed two's complement |
| op_b | input | 8 | Operand B, unsigned |
| acc_out | output | 24 | Accumulator value, signed two's complement |

## Verification
Every mode is driven with the same set of operand bytes. The set includes zero, the most negative and most positive A, all-ones values, single-bit B values, and bytes with junk above the selected width. Results that differ between modes therefore show errors in narrowing and extension, and modes 6 and 7 can be compared against 8×8. Long runs of one repeated narrow product, first positive and then negative, force carries and borrows across both segment boundaries. These runs show whether a sleeping upper segment fails to wake. A long run of the largest 8×8 product drives the accumulator past 2^24, and the largest negative product then brings it back through zero, which tests the wrap.

// File: rtl/mpmac_pkg.sv
package mpmac_pkg;

  typedef enum logic [2:0] {
    M_A2B2 = 3'd0,
    M_A2B4 = 3'd1,
    M_A2B8 = 3'd2,
    M_A4B4 = 3'd3,
    M_A4B8 = 3'd4,
    M_A8B8 = 3'd5,
    M_RSV6 = 3'd6,
    M_RSV7 = 3'd7
  } prec_mode_e;

  // width of the signed operand for a mode
  function automatic int a_width(input logic [2:0] m);
    case (prec_mode_e'(m))
      M_A2B2, M_A2B4, M_A2B8: return 2;
      M_A4B4, M_A4B8:         return 4;
      default:                return 8;
    endcase
  endfunction

  // width of the unsigned operand for a mode
  function automatic int b_width(input logic [2:0] m);
    case (prec_mode_e'(m))
      M_A2B2:         return 2;
      M_A2B4, M_A4B4: return 4;
      default:        return 8;
    endcase
  endfunction

  // accumulator segments a product of this mode can reach without sign/carry
  function automatic int seg_need(input logic [2:0] m, input int seg_w);
    return (a_width(m) + b_width(m) + seg_w - 1) / seg_w;
  endfunction

endpackage

// File: rtl/mpmac_opnd_fmt.sv
module mpmac_opnd_fmt #(
  parameter int OP_W = 8
) (
  input  logic [2:0]      mode,
  input  logic [OP_W-1:0] a_raw,
  input  logic [OP_W-1:0] b_raw,
  output logic [OP_W-1:0] a_ext,
  output logic [OP_W-1:0] b_ext,
  output logic            zero_op
);
  import mpmac_pkg::*;

  int aw;
  int bw;

  always_comb begin
    aw = a_width(mode);
    bw = b_width(mode);
    for (int i = 0; i < OP_W; i++) begin
      a_ext[i] = (i < aw) ? a_raw[i] : a_raw[aw-1];
      b_ext[i] = (i < bw) ? b_raw[i] : 1'b0;
    end
    zero_op = (a_ext == '0) || (b_ext == '0);
  end

endmodule

// File: rtl/mpmac_sa_mul.sv
module mpmac_sa_mul #(
  parameter int OP_W = 8,
  localparam int PW  = 2 * OP_W
) (
  input  logic                 run,
  input  logic [OP_W-1:0]      a_ext,
  input  logic [OP_W-1:0]      b_ext,
  output logic [OP_W-1:0]      pp_live,
  output logic signed [PW-1:0] product
);

  logic signed [PW-1:0] a_wide;
  assign a_wide = PW'($signed(a_ext));

  // one shifted copy of A per set multiplier bit; nothing when idle
  always_comb begin
    product = '0;
    for (int i = 0; i < OP_W; i++) begin
      pp_live[i] = run & b_ext[i];
      if (pp_live[i]) product = product + (a_wide << i);
    end
  end

endmodule

// File: rtl/mpmac_cla_seg.sv
module mpmac_cla_seg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] addend,
  input  logic         cin,
  output logic [W-1:0] q,
  output logic         cout
);

  // flat lookahead: every carry from generate/propagate terms directly
  function automatic logic [W:0] lookahead(input logic [W-1:0] g,
                                           input logic [W-1:0] p,
                                           input logic c0);
    logic [W:0] c;
    logic term;
    c = '0;
    c[0] = c0;
    for (int i = 0; i < W; i++) begin
      term = c0;
      for (int j = 0; j <= i; j++) term = term & p[j];
      c[i+1] = term;
      for (int j = 0; j <= i; j++) begin
        term = g[j];
        for (int k = j + 1; k <= i; k++) term = term & p[k];
        c[i+1] = c[i+1] | term;
      end
    end
    return c;
  endfunction

  logic [W-1:0] gen, prop, sum;
  logic [W:0]   cy;

  assign gen  = q & addend;
  assign prop = q ^ addend;
  assign cy   = lookahead(gen, prop, cin);
  assign sum  = prop ^ cy[W-1:0];
  assign cout = cy[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= sum;
  end

endmodule

// File: rtl/mixed_prec_mac.sv
module mixed_prec_mac #(
  parameter int OP_W  = 8,
  parameter int SEG_W = 8,
  parameter int N_SEG = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   in_valid,
  input  logic [2:0]             mode,
  input  logic [OP_W-1:0]        op_a,
  input  logic [OP_W-1:0]        op_b,
  output logic [SEG_W*N_SEG-1:0] acc_out
);
  import mpmac_pkg::*;

  localparam int PROD_W = 2 * OP_W;
  localparam int ACC_W  = SEG_W * N_SEG;

  logic [OP_W-1:0]          a_ext, b_ext, pp_live;
  logic                     zero_op, mul_run;
  logic signed [PROD_W-1:0] product;
  logic [ACC_W-1:0]         addend;
  logic [N_SEG-1:0]         seg_en;
  logic [N_SEG:0]           carry;
  int                       need_segs;

  mpmac_opnd_fmt #(.OP_W(OP_W)) u_fmt (
    .mode(mode), .a_raw(op_a), .b_raw(op_b),
    .a_ext(a_ext), .b_ext(b_ext), .zero_op(zero_op)
  );

  // zero-aware gate: multiply and update only for a live nonzero pair
  assign mul_run = in_valid & ~clr & ~zero_op;

  mpmac_sa_mul #(.OP_W(OP_W)) u_mul (
    .run(mul_run), .a_ext(a_ext), .b_ext(b_ext),
    .pp_live(pp_live), .product(product)
  );

  assign addend    = ACC_W'(product);
  assign need_segs = seg_need(mode, SEG_W);
  assign carry[0]  = 1'b0;

  for (genvar k = 0; k < N_SEG; k++) begin : g_seg
    assign seg_en[k] = mul_run & ((k < need_segs) | carry[k]
                                  | (|addend[k*SEG_W +: SEG_W]));
    mpmac_cla_seg #(.W(SEG_W)) u_seg (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(seg_en[k]),
      .addend(addend[k*SEG_W +: SEG_W]), .cin(carry[k]),
      .q(acc_out[k*SEG_W +: SEG_W]), .cout(carry[k+1])
    );
  end

endmodule

// File: rtl/mpmac_checker.sv
module mpmac_checker #(
  parameter int OP_W  = 8,
  parameter int SEG_W = 8,
  parameter int N_SEG = 3,
  localparam int ACC_W = SEG_W * N_SEG
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             in_valid,
  input logic             zero_op,
  input logic             mul_run,
  input logic [OP_W-1:0]  b_ext,
  input logic [OP_W-1:0]  pp_live,
  input logic [ACC_W-1:0] addend,
  input logic [N_SEG-1:0] seg_en,
  input logic [N_SEG-1:0] seg_cin,
  input logic [ACC_W-1:0] acc_out
);

  a_r3_sum: assert property (@(posedge clk) disable iff (!rst_n)
    mul_run |=> acc_out == $past(acc_out + addend));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> $stable(acc_out));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc_out == '0);

  a_r6_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr && zero_op) |=> $stable(acc_out));

  a_r6_no_seg: assert property (@(posedge clk) disable iff (!rst_n)
    zero_op |-> seg_en == '0);

  a_r7_pp_mask: assert property (@(posedge clk) disable iff (!rst_n)
    mul_run |-> pp_live == b_ext);

  a_r7_pp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !mul_run |-> pp_live == '0);

  for (genvar k = 0; k < N_SEG; k++) begin : g_chk
    a_r8_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !seg_en[k]) |=> $stable(acc_out[k*SEG_W +: SEG_W]));
  end

  for (genvar k = 1; k < N_SEG; k++) begin : g_wake
    a_r8_carry_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_run && seg_cin[k-1]) |-> seg_en[k]);
  end

  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_run && seg_cin[N_SEG-1] && !addend[ACC_W-1])
      |=> acc_out < $past(acc_out));

endmodule

bind mixed_prec_mac mpmac_checker #(.OP_W(OP_W), .SEG_W(SEG_W), .N_SEG(N_SEG)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
  .zero_op(zero_op), .mul_run(mul_run), .b_ext(b_ext), .pp_live(pp_live),
  .addend(addend), .seg_en(seg_en), .seg_cin(carry[N_SEG:1]), .acc_out(acc_out)
);

// File: tb/tb_mixed_prec_mac.sv
module tb_mixed_prec_mac;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [7:0]  op_a = 8'h00;
  logic [7:0]  op_b = 8'h00;
  logic [23:0] acc_out;

  int n_chk = 0;
  int n_err = 0;
  int acc_m = 0;
  bit done = 1'b0;

  logic [23:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  mixed_prec_mac dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .mode(mode), .op_a(op_a), .op_b(op_b), .acc_out(acc_out)
  );

  // arithmetic restatement of the mode table (R1, R2)
  function automatic int model_prod(input logic [2:0] m, input logic [7:0] a,
                                    input logic [7:0] b);
    int aw, bw, av, bv;
    case (m)
      3'd0, 3'd1, 3'd2: aw = 2;
      3'd3, 3'd4:       aw = 4;
      default:          aw = 8;
    endcase
    case (m)
      3'd0:       bw = 2;
      3'd1, 3'd3: bw = 4;
      default:    bw = 8;
    endcase
    av = int'(a) % (1 << aw);
    if (av >= (1 << (aw - 1))) av = av - (1 << aw);
    bv = int'(b) % (1 << bw);
    return av * bv;
  endfunction

  task automatic step(input logic c, input logic v, input logic [2:0] m,
                      input logic [7:0] a, input logic [7:0] b, input string tag);
    @(negedge clk);
    clr = c; in_valid = v; mode = m; op_a = a; op_b = b;
    if (c)      acc_m = 0;
    else if (v) acc_m = (acc_m + model_prod(m, a, b)) & 32'h00FF_FFFF;
    exp_q.push_back(acc_m[23:0]);
    tag_q.push_back(tag);
  endtask

  // monitor: one expected item per driven cycle, compared after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (acc_out !== e) begin
          n_err++;
          $display("FAIL %s acc_out=%h expected=%h", t, acc_out, e);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog acc_out=%h expected=finish", acc_out);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] a_set[8];
    logic [7:0] b_set[5];
    a_set = '{8'h01, 8'h7F, 8'h80, 8'hFF, 8'h02, 8'hAB, 8'h00, 8'h56};
    b_set = '{8'hFF, 8'h03, 8'h00, 8'h80, 8'hC5};

    // R10: reset value
    repeat (2) @(posedge clk);
    #2;
    n_chk++;
    if (acc_out !== 24'h0) begin
      n_err++;
      $display("FAIL R10 acc_out=%h expected=%h", acc_out, 24'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R7: every mode against one operand set
    for (int m = 0; m < 8; m++) begin
      step(1'b1, 1'b0, 3'd0, 8'h00, 8'h00, "R5");
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 5; j++)
          step(1'b0, 1'b1, 3'(m), a_set[i], b_set[j],
               (m < 6) ? "R1 R3 R7" : "R2 R3");
    end

    // R6: operands that become zero after narrowing leave acc unchanged
    step(1'b0, 1'b1, 3'd0, 8'hFC, 8'hFF, "R6");
    step(1'b0, 1'b1, 3'd3, 8'h07, 8'hF0, "R6");
    step(1'b0, 1'b1, 3'd1, 8'h30, 8'h0F, "R6");

    // R4: valid low holds despite live operands
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 3'd5, 8'h7F, 8'hFF, "R4");

    // R5: clear beats valid
    step(1'b1, 1'b1, 3'd5, 8'h7F, 8'hFF, "R5");
    step(1'b0, 1'b1, 3'd5, 8'h80, 8'hFF, "R3");
    step(1'b1, 1'b1, 3'd2, 8'h01, 8'h80, "R5");

    // R8: narrow products carrying up, then borrowing down across segments
    for (int i = 0; i < 700; i++) step(1'b0, 1'b1, 3'd3, 8'h07, 8'h0F, "R8");
    for (int i = 0; i < 1400; i++) step(1'b0, 1'b1, 3'd3, 8'h08, 8'h0F, "R8");
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 3'd0, 8'h01, 8'h03, "R8");

    // R9: wrap past 2^24 and back through zero
    step(1'b1, 1'b0, 3'd5, 8'h00, 8'h00, "R5");
    for (int i = 0; i < 520; i++) step(1'b0, 1'b1, 3'd5, 8'h7F, 8'hFF, "R9");
    for (int i = 0; i < 530; i++) step(1'b0, 1'b1, 3'd7, 8'h80, 8'hFF, "R9 R2");

    step(1'b0, 1'b0, 3'd0, 8'h00, 8'h00, "R4");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule